// File: doc/BRIEF.md
# Dual-Issue Pairing Steer

This block sits in the decode stage of an in-order core that has two integer execution pipes, a primary pipe U and a secondary pipe V. In every cycle it inspects the two oldest pre-decoded entries of the instruction queue, the head and the one behind it. It decides whether both can leave together or only the head can leave. The older entry always goes to U. The younger entry may join it in V only when both entries are single-cycle, non-sequenced operations and the younger one neither reads nor overwrites the register that the older one writes.

The number of entries to remove from the queue is reported in the same cycle, so the queue can advance and present the next pair at once. A younger entry that was held back becomes the head of the next candidate pair and is judged again against the entry that follows it. The U and V issue slots are registered, so the entries chosen in one cycle appear at the pipe inputs after the next clock edge. A stall input freezes the decision. It removes nothing and puts a bubble into both slots until it is released.

Top module: `pair_steer`

## Requirements
- R1: The head entry is always the one that issues to U. When the head is not valid, nothing issues and the pop count is 0, whatever the second entry holds. When the head is valid and there is no stall, the pop count is at least 1.
- R2: When both entries are valid and simple and there is no register conflict, the pop count is 2. After the next clock edge both slot valids are high, U carries the head's destination and V carries the second entry's destination. If the second entry writes a register that the head reads, the pair still issues.
- R3: If either entry is not simple (its simple flag is 0), only the head issues and the pop count is 1.
- R4: If the head's destination is non-zero and equals either source index of the second entry, only the head issues and the pop count is 1.
- R5: If both entries name the same non-zero destination, only the head issues and the pop count is 1.
- R6: Register index 0 means no destination and never creates a conflict, even when source or destination indices of the second entry are 0.
- R7: The pop count is encoded 0, 1 or 2 on a 2-bit port and never reads 3. With only the head valid, the pop count is 1 and only U issues. A pop count of n is followed after the clock edge by exactly n valid slots.
- R8: While stall_i is high, the pop count is 0 and after the edge both slot valids are low. Once stall_i falls, the same inputs produce the same decision as without the stall.
- R9: A synchronous reset clears both slot valids and both slot destination fields to 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Holds issue; nothing is popped |
| hd_vld_i | input | 1 | Head entry valid |
| hd_simple_i | input | 1 | Head entry is single-cycle, non-sequenced |
| hd_dst_i | input | REG_W | Head destination index (0 = none) |
| hd_srca_i | input | REG_W | Head first source index |
| hd_srcb_i | input | REG_W | Head second source index |
| nx_vld_i | input | 1 | Second entry valid |
| nx_simple_i | input | 1 | Second entry is single-cycle, non-sequenced |
| nx_dst_i | input | REG_W | Second entry destination index (0 = none) |
| nx_srca_i | input | REG_W | Second entry first source index |
| nx_srcb_i | input | REG_W | Second entry second source index |
| pop_o | output | 2 | Entries consumed this cycle (0, 1, 2) |
| u_vld_o | output | 1 | Registered U slot valid |
| u_dst_o | output | REG_W | Registered U slot destination |
| v_vld_o | output | 1 | Registered V slot valid |
| v_dst_o | output | REG_W | Registered V slot destination |

## Verification
A wrong pairing decision shows up in pop_o in the same cycle it is made. The queue then drifts away from the model, so a single bad pop puts the wrong entries in the slots from the next edge onward. A fault in the slot registers shows up one edge later, as a V slot without a U slot or a destination copied from the wrong entry. The random stream draws destinations and sources from a small range of register indices, so that read and write conflicts, index 0 and back-to-back rejections of the same younger entry all occur often.

// File: rtl/pair_pkg.sv
package pair_pkg;
  typedef enum logic [1:0] {
    POP_NONE = 2'd0,
    POP_ONE  = 2'd1,
    POP_TWO  = 2'd2
  } pop_e;

  localparam int NUM_SRC = 2;
endpackage

// File: rtl/pair_dep_check.sv
module pair_dep_check #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] old_dst_i,
  input  logic [REG_W-1:0] yng_dst_i,
  input  logic [REG_W-1:0] yng_src_i [pair_pkg::NUM_SRC],
  output logic             raw_o,
  output logic             waw_o
);
  localparam logic [REG_W-1:0] NO_REG = '0;

  logic                      old_writes;
  logic [pair_pkg::NUM_SRC-1:0] src_hit;

  assign old_writes = (old_dst_i != NO_REG);

  for (genvar s = 0; s < pair_pkg::NUM_SRC; s++) begin : g_src
    assign src_hit[s] = old_writes && (yng_src_i[s] == old_dst_i);
  end

  assign raw_o = |src_hit;
  assign waw_o = old_writes && (yng_dst_i == old_dst_i);
endmodule

// File: rtl/pair_decide.sv
module pair_decide
  import pair_pkg::*;
(
  input  logic stall_i,
  input  logic hd_vld_i,
  input  logic hd_simple_i,
  input  logic nx_vld_i,
  input  logic nx_simple_i,
  input  logic raw_i,
  input  logic waw_i,
  output pop_e pop_o,
  output logic take_u_o,
  output logic take_v_o
);
  logic both_simple;
  logic conflict;
  logic can_pair;

  assign both_simple = hd_simple_i && nx_simple_i;
  assign conflict    = raw_i || waw_i;
  assign can_pair    = nx_vld_i && both_simple && !conflict;

  always_comb begin
    pop_o    = POP_NONE;
    take_u_o = 1'b0;
    take_v_o = 1'b0;
    if (!stall_i && hd_vld_i) begin
      take_u_o = 1'b1;
      if (can_pair) begin
        pop_o    = POP_TWO;
        take_v_o = 1'b1;
      end else begin
        pop_o = POP_ONE;
      end
    end
  end
endmodule

// File: rtl/pair_issue_reg.sv
module pair_issue_reg #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take_u_i,
  input  logic             take_v_i,
  input  logic [REG_W-1:0] u_dst_i,
  input  logic [REG_W-1:0] v_dst_i,
  output logic             u_vld_o,
  output logic [REG_W-1:0] u_dst_o,
  output logic             v_vld_o,
  output logic [REG_W-1:0] v_dst_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      u_vld_o <= 1'b0;
      v_vld_o <= 1'b0;
      u_dst_o <= '0;
      v_dst_o <= '0;
    end else begin
      u_vld_o <= take_u_i;
      v_vld_o <= take_v_i;
      u_dst_o <= take_u_i ? u_dst_i : '0;
      v_dst_o <= take_v_i ? v_dst_i : '0;
    end
  end
endmodule

// File: rtl/pair_steer.sv
module pair_steer #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stall_i,
  input  logic             hd_vld_i,
  input  logic             hd_simple_i,
  input  logic [REG_W-1:0] hd_dst_i,
  input  logic [REG_W-1:0] hd_srca_i,
  input  logic [REG_W-1:0] hd_srcb_i,
  input  logic             nx_vld_i,
  input  logic             nx_simple_i,
  input  logic [REG_W-1:0] nx_dst_i,
  input  logic [REG_W-1:0] nx_srca_i,
  input  logic [REG_W-1:0] nx_srcb_i,
  output logic [1:0]       pop_o,
  output logic             u_vld_o,
  output logic [REG_W-1:0] u_dst_o,
  output logic             v_vld_o,
  output logic [REG_W-1:0] v_dst_o
);
  import pair_pkg::*;

  logic             raw;
  logic             waw;
  logic             take_u;
  logic             take_v;
  pop_e             pop_sel;
  logic [REG_W-1:0] nx_src [NUM_SRC];
  logic             hd_srcs_unused;

  assign nx_src[0] = nx_srca_i;
  assign nx_src[1] = nx_srcb_i;
  // The head's sources matter only to older producers already in flight.
  assign hd_srcs_unused = ^{hd_srca_i, hd_srcb_i};

  pair_dep_check #(.REG_W(REG_W)) dep_i (
    .old_dst_i (hd_dst_i),
    .yng_dst_i (nx_dst_i),
    .yng_src_i (nx_src),
    .raw_o     (raw),
    .waw_o     (waw)
  );

  pair_decide dec_i (
    .stall_i     (stall_i),
    .hd_vld_i    (hd_vld_i),
    .hd_simple_i (hd_simple_i),
    .nx_vld_i    (nx_vld_i),
    .nx_simple_i (nx_simple_i),
    .raw_i       (raw),
    .waw_i       (waw),
    .pop_o       (pop_sel),
    .take_u_o    (take_u),
    .take_v_o    (take_v)
  );

  pair_issue_reg #(.REG_W(REG_W)) slot_i (
    .clk      (clk),
    .rst      (rst),
    .take_u_i (take_u),
    .take_v_i (take_v),
    .u_dst_i  (hd_dst_i),
    .v_dst_i  (nx_dst_i),
    .u_vld_o  (u_vld_o),
    .u_dst_o  (u_dst_o),
    .v_vld_o  (v_vld_o),
    .v_dst_o  (v_dst_o)
  );

  assign pop_o = pop_sel;
endmodule

// File: rtl/pair_steer_chk.sv
module pair_steer_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             stall_i,
  input logic             hd_vld_i,
  input logic             hd_simple_i,
  input logic [REG_W-1:0] hd_dst_i,
  input logic             nx_vld_i,
  input logic             nx_simple_i,
  input logic [REG_W-1:0] nx_dst_i,
  input logic [REG_W-1:0] nx_srca_i,
  input logic [REG_W-1:0] nx_srcb_i,
  input logic [1:0]       pop_o,
  input logic             u_vld_o,
  input logic             v_vld_o
);
  assert_head_gate_R1: assert property (@(posedge clk) disable iff (rst)
    !hd_vld_i |-> pop_o == 2'd0);

  assert_head_moves_R1: assert property (@(posedge clk) disable iff (rst)
    (hd_vld_i && !stall_i) |-> pop_o != 2'd0);

  assert_v_needs_u_R2: assert property (@(posedge clk) disable iff (rst)
    v_vld_o |-> u_vld_o);

  assert_simple_only_R3: assert property (@(posedge clk) disable iff (rst)
    (!hd_simple_i || !nx_simple_i) |-> pop_o != 2'd2);

  assert_raw_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (hd_dst_i != '0 && (nx_srca_i == hd_dst_i || nx_srcb_i == hd_dst_i))
      |-> pop_o != 2'd2);

  assert_waw_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    (hd_dst_i != '0 && nx_dst_i == hd_dst_i) |-> pop_o != 2'd2);

  assert_pop_range_R7: assert property (@(posedge clk) disable iff (rst)
    pop_o != 2'd3);

  assert_pop_fills_R7: assert property (@(posedge clk) disable iff (rst)
    pop_o == 2'd2 |=> (u_vld_o && v_vld_o));

  assert_pop_one_R7: assert property (@(posedge clk) disable iff (rst)
    pop_o == 2'd1 |=> (u_vld_o && !v_vld_o));

  assert_stall_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    stall_i |-> pop_o == 2'd0);

  assert_stall_bubble_R8: assert property (@(posedge clk) disable iff (rst)
    stall_i |=> (!u_vld_o && !v_vld_o));

  assert_two_needs_next_R2: assert property (@(posedge clk) disable iff (rst)
    !nx_vld_i |-> pop_o != 2'd2);
endmodule

bind pair_steer pair_steer_chk #(.REG_W(REG_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .stall_i     (stall_i),
  .hd_vld_i    (hd_vld_i),
  .hd_simple_i (hd_simple_i),
  .hd_dst_i    (hd_dst_i),
  .nx_vld_i    (nx_vld_i),
  .nx_simple_i (nx_simple_i),
  .nx_dst_i    (nx_dst_i),
  .nx_srca_i   (nx_srca_i),
  .nx_srcb_i   (nx_srcb_i),
  .pop_o       (pop_o),
  .u_vld_o     (u_vld_o),
  .v_vld_o     (v_vld_o)
);

// File: tb/pair_steer_tb_top.sv
module pair_steer_tb_top;
  localparam int RW = 5;
  localparam int NVEC = 14;
  localparam int VW = 1 + 2 * (2 + 3 * RW) + 2;
  localparam int QN = 400;

  // {stall, hv, hs, hd, ha, hb, nv, ns, nd, na, nb, expected pop}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 1'b1, 5'd3, 5'd1, 5'd2,   1'b1, 1'b1, 5'd4, 5'd5, 5'd6,  2'd2}, // R2 pair
    {1'b0, 1'b1, 1'b1, 5'd3, 5'd1, 5'd2,   1'b1, 1'b1, 5'd4, 5'd3, 5'd6,  2'd1}, // R4 src a
    {1'b0, 1'b1, 1'b1, 5'd3, 5'd1, 5'd2,   1'b1, 1'b1, 5'd4, 5'd5, 5'd3,  2'd1}, // R4 src b
    {1'b0, 1'b1, 1'b1, 5'd7, 5'd1, 5'd2,   1'b1, 1'b1, 5'd7, 5'd5, 5'd6,  2'd1}, // R5 waw
    {1'b0, 1'b1, 1'b1, 5'd0, 5'd1, 5'd2,   1'b1, 1'b1, 5'd0, 5'd0, 5'd0,  2'd2}, // R6 zero
    {1'b0, 1'b1, 1'b0, 5'd3, 5'd1, 5'd2,   1'b1, 1'b1, 5'd4, 5'd5, 5'd6,  2'd1}, // R3 head
    {1'b0, 1'b1, 1'b1, 5'd3, 5'd1, 5'd2,   1'b1, 1'b0, 5'd4, 5'd5, 5'd6,  2'd1}, // R3 next
    {1'b0, 1'b1, 1'b1, 5'd3, 5'd1, 5'd2,   1'b0, 1'b1, 5'd4, 5'd5, 5'd6,  2'd1}, // R7 one
    {1'b0, 1'b0, 1'b1, 5'd3, 5'd1, 5'd2,   1'b0, 1'b1, 5'd4, 5'd5, 5'd6,  2'd0}, // R7 none
    {1'b0, 1'b0, 1'b1, 5'd3, 5'd1, 5'd2,   1'b1, 1'b1, 5'd4, 5'd5, 5'd6,  2'd0}, // R1 head off
    {1'b1, 1'b1, 1'b1, 5'd3, 5'd1, 5'd2,   1'b1, 1'b1, 5'd4, 5'd5, 5'd6,  2'd0}, // R8 stall
    {1'b0, 1'b1, 1'b1, 5'd3, 5'd1, 5'd2,   1'b1, 1'b1, 5'd4, 5'd5, 5'd6,  2'd2}, // R8 release
    {1'b0, 1'b1, 1'b1, 5'd31, 5'd1, 5'd2,  1'b1, 1'b1, 5'd4, 5'd9, 5'd31, 2'd1}, // R4 top index
    {1'b0, 1'b1, 1'b1, 5'd3, 5'd1, 5'd2,   1'b1, 1'b1, 5'd1, 5'd5, 5'd6,  2'd2}  // R2 war ok
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          stall_i = 1'b0;
  logic          hd_vld_i = 1'b0, hd_simple_i = 1'b0;
  logic [RW-1:0] hd_dst_i = '0, hd_srca_i = '0, hd_srcb_i = '0;
  logic          nx_vld_i = 1'b0, nx_simple_i = 1'b0;
  logic [RW-1:0] nx_dst_i = '0, nx_srca_i = '0, nx_srcb_i = '0;
  logic [1:0]    pop_o;
  logic          u_vld_o, v_vld_o;
  logic [RW-1:0] u_dst_o, v_dst_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic          q_s [QN];
  logic [RW-1:0] q_d [QN];
  logic [RW-1:0] q_a [QN];
  logic [RW-1:0] q_b [QN];

  always #2.5 clk = ~clk;

  pair_steer #(.REG_W(RW)) dut_i (
    .clk(clk), .rst(rst), .stall_i(stall_i),
    .hd_vld_i(hd_vld_i), .hd_simple_i(hd_simple_i), .hd_dst_i(hd_dst_i),
    .hd_srca_i(hd_srca_i), .hd_srcb_i(hd_srcb_i),
    .nx_vld_i(nx_vld_i), .nx_simple_i(nx_simple_i), .nx_dst_i(nx_dst_i),
    .nx_srca_i(nx_srca_i), .nx_srcb_i(nx_srcb_i),
    .pop_o(pop_o), .u_vld_o(u_vld_o), .u_dst_o(u_dst_o),
    .v_vld_o(v_vld_o), .v_dst_o(v_dst_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pairing rules written from the requirements.
  function automatic int ref_pop(input logic st, input logic hv, input logic hs,
                                 input logic [RW-1:0] hd, input logic nv, input logic ns,
                                 input logic [RW-1:0] nd, input logic [RW-1:0] na,
                                 input logic [RW-1:0] nb);
    bit dep;
    if (st || !hv) return 0;
    dep = (hd != 0) && (na == hd || nb == hd || nd == hd);
    if (nv && hs && ns && !dep) return 2;
    return 1;
  endfunction

  // Drives one pair, checks pop at once and the slots after the edge.
  task automatic apply(input string req, input int exp_pop);
    chk({req, " pop"}, int'(pop_o), exp_pop);
    @(posedge clk);
    #1;
    chk({req, " u_vld"}, int'(u_vld_o), int'(exp_pop >= 1));
    chk({req, " v_vld"}, int'(v_vld_o), int'(exp_pop == 2));
    chk({req, " u_dst"}, int'(u_dst_o), (exp_pop >= 1) ? int'(hd_dst_i) : 0);
    chk({req, " v_dst"}, int'(v_dst_o), (exp_pop == 2) ? int'(nx_dst_i) : 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset u_vld", int'(u_vld_o), 0);
    chk("R9 reset v_vld", int'(v_vld_o), 0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {stall_i, hd_vld_i, hd_simple_i, hd_dst_i, hd_srca_i, hd_srcb_i,
       nx_vld_i, nx_simple_i, nx_dst_i, nx_srca_i, nx_srcb_i} = VEC[i][VW-1:2];
      #1;
      apply($sformatf("R1-table vec%0d", i), int'(VEC[i][1:0]));
    end

    // R9: reset with a pairable pair at the inputs empties both slots.
    @(negedge clk);
    {stall_i, hd_vld_i, hd_simple_i, hd_dst_i, nx_vld_i, nx_simple_i, nx_dst_i} =
      {1'b0, 1'b1, 1'b1, 5'd9, 1'b1, 1'b1, 5'd10};
    nx_srca_i = 5'd1; nx_srcb_i = 5'd2;
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R9 u_vld", int'(u_vld_o), 0);
    chk("R9 v_vld", int'(v_vld_o), 0);
    chk("R9 u_dst", int'(u_dst_o), 0);
    chk("R9 v_dst", int'(v_dst_o), 0);
    @(negedge clk);
    rst = 1'b0;

    // Random stream through a model queue; rejected younger entries become heads (R2..R8).
    for (int k = 0; k < QN; k++) begin
      q_s[k] = ($urandom_range(0, 5) != 0);
      q_d[k] = RW'($urandom_range(0, 4));
      q_a[k] = RW'($urandom_range(0, 4));
      q_b[k] = RW'($urandom_range(0, 4));
    end
    begin
      int head = 0;
      while (head <= QN) begin
        int ep;
        @(negedge clk);
        stall_i     = ($urandom_range(0, 4) == 0);
        hd_vld_i    = (head < QN);
        nx_vld_i    = (head + 1 < QN);
        hd_simple_i = hd_vld_i ? q_s[head] : 1'b0;
        hd_dst_i    = hd_vld_i ? q_d[head] : '0;
        hd_srca_i   = hd_vld_i ? q_a[head] : '0;
        hd_srcb_i   = hd_vld_i ? q_b[head] : '0;
        nx_simple_i = nx_vld_i ? q_s[head+1] : 1'b0;
        nx_dst_i    = nx_vld_i ? q_d[head+1] : '0;
        nx_srca_i   = nx_vld_i ? q_a[head+1] : '0;
        nx_srcb_i   = nx_vld_i ? q_b[head+1] : '0;
        ep = ref_pop(stall_i, hd_vld_i, hd_simple_i, hd_dst_i, nx_vld_i,
                     nx_simple_i, nx_dst_i, nx_srca_i, nx_srcb_i);
        #1;
        apply("R7 stream", ep);
        if (!hd_vld_i) break;
        head += ep;
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule